// File: doc/BRIEF.md
# Short Arbitrated Bus Reset Controller

This block decides when a serial-bus node drives a bus reset onto its cable ports and how long that reset lasts. Software raises one of two register bits: a bit that forces a normal (long) reset, and a bit that asks for a short reset that is first won through fair arbitration. A strap input enables the short mode. The controller also watches whether the bus has been initialized, the fair-arbitration grant and lost indications, and a confirmation from the line monitor that the reset was observed on the bus.

When short mode is strapped on and the bus is already initialized, a short-reset request is turned into a fair-arbitration request. On the grant, a short pulse is driven in place of a packet. Before initialization, the short pulse is driven at once. A short pulse that the line monitor does not confirm within a timeout is followed by a long pulse. Each completed reset ends with a one-cycle done strobe, which the register file uses to clear both request bits. All pulse lengths are counted in system-clock cycles. The defaults, 69 and 8160, match about 1.4 µs and 166 µs at 49.152 MHz.

Top module: `bus_reset_ctrl`

## Requirements
- R1: After reset, `fair_req_o`, `reset_drive_o` and `reset_done_o` are all low, and they stay low while no request bit is set.
- R2: A set `long_req_i` bit makes `reset_drive_o` go high for exactly LONG_CYCLES consecutive cycles, starting the cycle after the bit is first sampled, whatever the strap value.
- R3: With `short_mode_i` low, a set `arb_req_i` bit produces a long pulse of LONG_CYCLES cycles and never asserts `fair_req_o`.
- R4: With `short_mode_i` high and `bus_init_i` low, a set `arb_req_i` bit drives a short pulse of exactly SHORT_CYCLES cycles, starting the next cycle, with no fair request.
- R5: With `short_mode_i` high and `bus_init_i` high, a set `arb_req_i` bit raises `fair_req_o` and holds it until `fair_grant_i`. The cycle after the grant, `fair_req_o` is low and the short pulse of SHORT_CYCLES cycles begins.
- R6: A `fair_lost_i` indication while requesting leaves `fair_req_o` high and starts no pulse.
- R7: If `reset_seen_i` is not high during the short pulse or within the TIMEOUT_CYCLES cycles that follow it, a long pulse of LONG_CYCLES cycles follows at once. If it is seen, no long pulse follows.
- R8: If both request bits are set, the long reset is taken. This holds when both are set in the same cycle, and also when the long bit arrives while the block is waiting for a fair grant.
- R9: `reset_done_o` is high for exactly one cycle. That cycle directly follows the last drive cycle of a long pulse, or the cycle in which a short pulse was confirmed.
- R10: `fair_req_o`, `reset_drive_o` and `reset_done_o` are never high in the same cycle as each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_req_i | input | 1 | Register bit: request a normal long reset |
| arb_req_i | input | 1 | Register bit: request a short arbitrated reset |
| short_mode_i | input | 1 | Strap: high enables short-reset mode |
| bus_init_i | input | 1 | High once the bus has been initialized |
| fair_grant_i | input | 1 | Fair arbitration won |
| fair_lost_i | input | 1 | Fair arbitration attempt lost |
| reset_seen_i | input | 1 | Line monitor observed the reset on the bus |
| fair_req_o | output | 1 | Fair-arbitration request to the arbiter |
| reset_drive_o | output | 1 | Enables the line drivers to send the reset state |
| reset_done_o | output | 1 | One-cycle strobe that clears both request bits |

## Verification
A wrong phase or a corrupted count in this controller shows at the ports within one pulse length: a drive window one cycle short or long, a fair request that drops on a lost indication, or a done strobe that is missing or doubled. A confirmation flag that is not cleared when a short pulse starts shows up only after the timeout window, as a long pulse that never comes or one that should not be there. For that reason the bench runs short pulses both with and without confirmation, one after another. A reference model compares all three outputs on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_SHORT,
        ST_WAIT,
        ST_LONG,
        ST_DONE
    } brc_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LONG,
        ACT_SHORT_NOW,
        ACT_ARB
    } brc_act_e;

endpackage

// File: rtl/brc_req_decode.sv
module brc_req_decode
    import brc_pkg::*;
(
    input  logic     long_req_i,
    input  logic     arb_req_i,
    input  logic     short_mode_i,
    input  logic     bus_init_i,
    output brc_act_e act_o
);

    // Long request always wins; short mode needs the strap.
    always_comb begin
        act_o = ACT_NONE;
        if (long_req_i) begin
            act_o = ACT_LONG;
        end else if (arb_req_i) begin
            if (!short_mode_i) begin
                act_o = ACT_LONG;
            end else if (!bus_init_i) begin
                act_o = ACT_SHORT_NOW;
            end else begin
                act_o = ACT_ARB;
            end
        end
    end

endmodule

// File: rtl/brc_down_counter.sv
module brc_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.cnt = load_val_i;
        end else if (dec_i && (cur_q.cnt != '0)) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zero_o = (cur_q.cnt == '0);

endmodule

// File: rtl/bus_reset_ctrl.sv
module bus_reset_ctrl
    import brc_pkg::*;
#(
    parameter int SHORT_CYCLES   = 69,
    parameter int LONG_CYCLES    = 8160,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_req_i,
    input  logic arb_req_i,
    input  logic short_mode_i,
    input  logic bus_init_i,
    input  logic fair_grant_i,
    input  logic fair_lost_i,
    input  logic reset_seen_i,
    output logic fair_req_o,
    output logic reset_drive_o,
    output logic reset_done_o
);

    localparam int MAX_A = (SHORT_CYCLES > LONG_CYCLES) ? SHORT_CYCLES : LONG_CYCLES;
    localparam int MAX_C = (MAX_A > TIMEOUT_CYCLES) ? MAX_A : TIMEOUT_CYCLES;
    localparam int CW    = $clog2(MAX_C + 1);

    localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_CYCLES - 1);
    localparam logic [CW-1:0] TMO_LOAD   = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        brc_state_e state;
        logic       seen;
    } ctl_s;

    ctl_s cur_q, nxt_d;

    brc_act_e        act;
    logic            cnt_zero;
    logic            cnt_load;
    logic [CW-1:0]   cnt_val;
    logic            cnt_dec;

    brc_req_decode u_dec (
        .long_req_i   (long_req_i),
        .arb_req_i    (arb_req_i),
        .short_mode_i (short_mode_i),
        .bus_init_i   (bus_init_i),
        .act_o        (act)
    );

    brc_down_counter #(.W(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    always_comb begin
        nxt_d    = cur_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                unique case (act)
                    ACT_LONG: begin
                        nxt_d.state = ST_LONG;
                        cnt_load    = 1'b1;
                        cnt_val     = LONG_LOAD;
                    end
                    ACT_SHORT_NOW: begin
                        nxt_d.state = ST_SHORT;
                        nxt_d.seen  = 1'b0;
                        cnt_load    = 1'b1;
                        cnt_val     = SHORT_LOAD;
                    end
                    ACT_ARB: begin
                        nxt_d.state = ST_ARB;
                    end
                    default: ;
                endcase
            end
            ST_ARB: begin
                if (long_req_i) begin
                    nxt_d.state = ST_LONG;
                    cnt_load    = 1'b1;
                    cnt_val     = LONG_LOAD;
                end else if (fair_grant_i) begin
                    nxt_d.state = ST_SHORT;
                    nxt_d.seen  = 1'b0;
                    cnt_load    = 1'b1;
                    cnt_val     = SHORT_LOAD;
                end else if (fair_lost_i) begin
                    nxt_d.state = ST_ARB;   // retry at next fair opportunity
                end
            end
            ST_SHORT: begin
                nxt_d.seen = cur_q.seen | reset_seen_i;
                if (cnt_zero) begin
                    nxt_d.state = ST_WAIT;
                    cnt_load    = 1'b1;
                    cnt_val     = TMO_LOAD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cur_q.seen || reset_seen_i) begin
                    nxt_d.state = ST_DONE;
                end else if (cnt_zero) begin
                    nxt_d.state = ST_LONG;
                    cnt_load    = 1'b1;
                    cnt_val     = LONG_LOAD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_LONG: begin
                if (cnt_zero) begin
                    nxt_d.state = ST_DONE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DONE: begin
                nxt_d.state = ST_IDLE;
                nxt_d.seen  = 1'b0;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, seen: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fair_req_o    = (cur_q.state == ST_ARB);
    assign reset_drive_o = (cur_q.state == ST_SHORT) || (cur_q.state == ST_LONG);
    assign reset_done_o  = (cur_q.state == ST_DONE);

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int SHORT_CYCLES = 69,
    parameter int LONG_CYCLES  = 8160
) (
    input logic clk,
    input logic rst_n,
    input logic long_req_i,
    input logic fair_grant_i,
    input logic fair_lost_i,
    input logic fair_req_o,
    input logic reset_drive_o,
    input logic reset_done_o
);

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (reset_drive_o) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R10: outputs mutually exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fair_req_o, reset_drive_o, reset_done_o}) <= 1);

    // R9: done strobe lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done_o |=> !reset_done_o);

    // R5: grant starts short pulse and drops request
    p_grant_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_req_o && fair_grant_i) |=> (reset_drive_o && !fair_req_o));

    // R6: lost attempt keeps the request
    p_lost_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_req_o && fair_lost_i && !fair_grant_i && !long_req_i) |=> fair_req_o);

    // R2 / R4: every drive window has one of the two lengths
    p_width_r2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_drive_o) |-> (run_q == SHORT_CYCLES || run_q == LONG_CYCLES));

    // R8: long bit during arbitration starts driving at once
    p_long_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_req_o && long_req_i) |=> (reset_drive_o && !fair_req_o));

endmodule

bind bus_reset_ctrl brc_checker #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
) u_brc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .long_req_i    (long_req_i),
    .fair_grant_i  (fair_grant_i),
    .fair_lost_i   (fair_lost_i),
    .fair_req_o    (fair_req_o),
    .reset_drive_o (reset_drive_o),
    .reset_done_o  (reset_done_o)
);

// File: tb/sim_bus_reset_ctrl.sv
module sim_bus_reset_ctrl;

    localparam int S_LEN = 6;
    localparam int L_LEN = 40;
    localparam int T_LEN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic long_bit = 1'b0, arb_bit = 1'b0;
    logic set_long = 1'b0, set_arb = 1'b0;
    logic mode = 1'b0, init = 1'b0, grant = 1'b0, lost = 1'b0, seen = 1'b0;
    logic fair_req, drive, done;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state: 0 idle,1 arb,2 short,3 wait,4 long,5 done
    int m_st = 0;
    int m_cnt = 0;
    bit m_seen = 0;
    bit m_clear;

    always #2 clk = ~clk;

    bus_reset_ctrl #(
        .SHORT_CYCLES   (S_LEN),
        .LONG_CYCLES    (L_LEN),
        .TIMEOUT_CYCLES (T_LEN)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .long_req_i    (long_bit),
        .arb_req_i     (arb_bit),
        .short_mode_i  (mode),
        .bus_init_i    (init),
        .fair_grant_i  (grant),
        .fair_lost_i   (lost),
        .reset_seen_i  (seen),
        .fair_req_o    (fair_req),
        .reset_drive_o (drive),
        .reset_done_o  (done)
    );

    always @(posedge clk) begin
        m_clear = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_seen = 0;
        end else begin
            case (m_st)
                0: begin
                    if (long_bit || (arb_bit && !mode)) begin
                        m_st = 4; m_cnt = L_LEN;
                    end else if (arb_bit && !init) begin
                        m_st = 2; m_cnt = S_LEN; m_seen = 0;
                    end else if (arb_bit) begin
                        m_st = 1;
                    end
                end
                1: begin
                    if (long_bit) begin
                        m_st = 4; m_cnt = L_LEN;
                    end else if (grant) begin
                        m_st = 2; m_cnt = S_LEN; m_seen = 0;
                    end
                end
                2: begin
                    if (seen) m_seen = 1;
                    m_cnt--;
                    if (m_cnt == 0) begin
                        m_st = 3; m_cnt = T_LEN;
                    end
                end
                3: begin
                    if (m_seen || seen) begin
                        m_st = 5;
                    end else begin
                        m_cnt--;
                        if (m_cnt == 0) begin
                            m_st = 4; m_cnt = L_LEN;
                        end
                    end
                end
                4: begin
                    m_cnt--;
                    if (m_cnt == 0) m_st = 5;
                end
                default: begin
                    m_st = 0; m_seen = 0; m_clear = 1'b1;
                end
            endcase
        end
        long_bit <= (!rst_n || m_clear) ? 1'b0 : (long_bit | set_long);
        arb_bit  <= (!rst_n || m_clear) ? 1'b0 : (arb_bit | set_arb);
    end

    // compare all outputs every cycle, away from the active edge
    always @(negedge clk) begin
        bit e_req, e_drv, e_done;
        e_req  = (m_st == 1);
        e_drv  = (m_st == 2) || (m_st == 4);
        e_done = (m_st == 5);
        vectors++;
        cycles++;
        if (fair_req !== e_req || drive !== e_drv || done !== e_done) begin
            fails++;
            $display("FAIL %s cycle %0d: req/drive/done = %b%b%b expected %b%b%b",
                     tag, cycles, fair_req, drive, done, e_req, e_drv, e_done);
        end
        // R10 exclusivity seen at the ports
        vectors++;
        if ((32'(fair_req) + 32'(drive) + 32'(done)) > 1) begin
            fails++;
            $display("FAIL R10 cycle %0d: outputs %b%b%b expected at most one high",
                     cycles, fair_req, drive, done);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_long();
        set_long = 1'b1; @(negedge clk); set_long = 1'b0;
    endtask

    task automatic pulse_arb();
        set_arb = 1'b1; @(negedge clk); set_arb = 1'b0;
    endtask

    task automatic pulse_grant();
        grant = 1'b1; @(negedge clk); grant = 1'b0;
    endtask

    task automatic pulse_lost();
        lost = 1'b1; @(negedge clk); lost = 1'b0;
    endtask

    task automatic pulse_seen();
        seen = 1'b1; @(negedge clk); seen = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (m_st == 0 && !long_bit && !arb_bit) break;
            @(negedge clk);
        end
        tick(2);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        tag = "R1";
        vectors++;
        if (fair_req !== 1'b0 || drive !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R1: outputs %b%b%b expected 000", fair_req, drive, done);
        end
        rst_n = 1'b1;
        tick(5);

        // R2: long bit, strap high
        tag = "R2"; mode = 1'b1; init = 1'b1;
        pulse_long(); wait_idle();

        // R3: strap low turns arbitrated request into long reset
        tag = "R3"; mode = 1'b0;
        pulse_arb(); wait_idle();

        // R4: not initialized, short pulse at once, confirmed during pulse
        tag = "R4"; mode = 1'b1; init = 1'b0;
        pulse_arb(); tick(3); pulse_seen(); wait_idle();

        // R5: initialized, arbitrate then short pulse, confirmed in window
        tag = "R5"; init = 1'b1;
        pulse_arb(); tick(4); pulse_grant(); tick(8); pulse_seen(); wait_idle();

        // R6: lost twice, then granted
        tag = "R6";
        pulse_arb(); tick(3); pulse_lost(); tick(5); pulse_lost(); tick(3);
        pulse_grant(); tick(S_LEN + 1); pulse_seen(); wait_idle();

        // R7: short pulse not confirmed, long fallback
        tag = "R7";
        pulse_arb(); tick(3); pulse_grant(); wait_idle();

        // R7: unarbitrated short pulse not confirmed
        tag = "R7"; init = 1'b0;
        pulse_arb(); wait_idle();

        // R8: both bits in same cycle
        tag = "R8"; init = 1'b1;
        set_long = 1'b1; set_arb = 1'b1; @(negedge clk);
        set_long = 1'b0; set_arb = 1'b0;
        wait_idle();

        // R8: long bit arrives while arbitrating
        tag = "R8";
        pulse_arb(); tick(4); pulse_long(); wait_idle();

        // R9: confirmation on the last cycle of the timeout window
        tag = "R9";
        pulse_arb(); tick(2); pulse_grant(); tick(S_LEN + T_LEN - 1); pulse_seen(); wait_idle();

        // R1: quiet with no request
        tag = "R1"; tick(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule